// File: doc/BRIEF.md
# GPIO Input Filter and Interrupt Detector

This block handles the input half of a general-purpose I/O unit with up to 32 pins. Every raw pin goes through a two-flop synchronizer. It then goes through a stability filter that software can switch on for each pin. The filtered levels are watched for four conditions, each selectable per pin: a rising edge, a falling edge, a high level and a low level. A condition that fires sets the pin's bit in a sticky interrupt state register. Software clears a state bit by writing 1 to it, and a test register lets software set state bits directly. The per-pin interrupt outputs are the state bits gated by a per-pin enable.

After reset, the block also takes one snapshot of the synchronized inputs as hardware straps. The snapshot is taken on the first cycle in which the strap enable input is high. It is then held, together with a valid flag, until the next reset. A parameter can remove the strap capture, and then both strap registers read as zero.

Software reaches the registers through a single-cycle write port and a combinational read port, using a 4-bit word index.

Top module: `pin_event_unit`

## Requirements
- R1: After reset, every register reads zero (index 0 interrupt state, 1 enable, 2 test, 3 rise mask, 4 fall mask, 5 high mask, 6 low mask, 7 filter enable, 8 filtered level, 9 strap valid, 10 strap data), and irq_o is zero.
- R2: With the filter off, a change on pin_i appears in the filtered level (index 8) exactly three clock edges after the input change, and not after two.
- R3: With its filter-enable bit (index 7) set, a pin's filtered level takes a new value only once 16 consecutive synchronized samples agree, that is 18 edges after a clean input change. A pulse shorter than that never reaches the filtered level or the state.
- R4: With rise mask bit i (index 3) set, a 0-to-1 change of the filtered level sets state bit i one edge after the filtered level changes. The fall mask (index 4) does the same for a 1-to-0 change. No edge is seen on the first cycle after reset.
- R5: With high mask bit i (index 5) set, state bit i is set on every edge on which filtered level i is 1. The low mask (index 6) does the same for level 0. This holds even right after software clears the bit.
- R6: Writing the state register (index 0) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R7: Writing 1 to a bit of the test register (index 2) sets the matching state bit on the next edge. The test register always reads zero.
- R8: When a detected condition and a software clear hit the same state bit in the same cycle, the bit ends up set.
- R9: irq_o bit i is 1 exactly when state bit i and enable bit i (index 1) are both 1.
- R10: With strap capture present, the synchronized inputs are stored in strap data (index 10) and strap valid (index 9, bit 0) becomes 1 on the first edge after reset at which strap_en_i is high. Later pulses of strap_en_i leave both unchanged.
- R11: With strap capture removed by parameter, strap valid and strap data read zero even after strap_en_i pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPINS | Raw pin levels |
| strap_en_i | input | 1 | Request for the one-time strap capture |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| irq_o | output | NPINS | Per-pin interrupt outputs |

## Verification
Each result has a fixed latency. A pin change reaches the filtered level after three edges without the filter and after eighteen with it. It reaches the state bit and irq_o one edge after that. A register write takes effect on the edge that samples it. The directed checks sample on the half-cycle just before and just after the due edge, so that a result arriving one edge early or late is caught. A behavioural model inside the bench advances on every rising edge and is compared with irq_o on every falling edge. The comparison covers a long stretch of random pin activity with mixed filter settings and masks, and with periodic software clears.

// File: rtl/pin_event_pkg.sv
package pin_event_pkg;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_STATE     = 4'd0,
        REG_ENABLE    = 4'd1,
        REG_TEST      = 4'd2,
        REG_RISE      = 4'd3,
        REG_FALL      = 4'd4,
        REG_HIGH      = 4'd5,
        REG_LOW       = 4'd6,
        REG_FILT      = 4'd7,
        REG_LEVEL     = 4'd8,
        REG_STRAP_OK  = 4'd9,
        REG_STRAP_VAL = 4'd10
    } reg_idx_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = raw_i;
        for (int k = 1; k < STAGES; k++) begin
            pipe_d[k] = pipe_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/pin_filter.sv
module pin_filter #(
    parameter int W    = 32,
    parameter int FILT = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    input  logic [W-1:0] en_i,
    output logic [W-1:0] filt_o
);
    localparam int CW = $clog2(FILT + 1);

    for (genvar gi = 0; gi < W; gi++) begin : g_pin
        typedef struct packed {
            logic          cand;
            logic [CW-1:0] cnt;
            logic          level;
        } fstate_t;

        fstate_t s_d, s_q;

        always_comb begin
            s_d = s_q;
            if (raw_i[gi] == s_q.cand) begin
                if (s_q.cnt != CW'(FILT)) s_d.cnt = s_q.cnt + 1'b1;
            end else begin
                s_d.cand = raw_i[gi];
                s_d.cnt  = CW'(1);
            end
            if (!en_i[gi] || s_d.cnt == CW'(FILT)) s_d.level = raw_i[gi];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= '0;
            else        s_q <= s_d;
        end

        assign filt_o[gi] = s_q.level;
    end
endmodule

// File: rtl/pin_event_detect.sv
module pin_event_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level_i,
    input  logic [W-1:0] rise_en_i,
    input  logic [W-1:0] fall_en_i,
    input  logic [W-1:0] high_en_i,
    input  logic [W-1:0] low_en_i,
    output logic [W-1:0] hit_o
);
    logic [W-1:0] prev_d, prev_q;
    logic [W-1:0] up, down;

    always_comb begin
        prev_d = level_i;
        up     = level_i & ~prev_q;
        down   = ~level_i & prev_q;
        hit_o  = (up & rise_en_i) | (down & fall_en_i)
               | (level_i & high_en_i) | (~level_i & low_en_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/pin_event_unit.sv
module pin_event_unit
    import pin_event_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int FILT_CYCLES = 16,
    parameter int SYNC_STAGES = 2,
    parameter bit STRAP_EN    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pin_i,
    input  logic              strap_en_i,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    output logic [NPINS-1:0]  irq_o
);
    typedef struct packed {
        logic [NPINS-1:0] state;
        logic [NPINS-1:0] enable;
        logic [NPINS-1:0] rise;
        logic [NPINS-1:0] fall;
        logic [NPINS-1:0] high;
        logic [NPINS-1:0] low;
        logic [NPINS-1:0] filt_en;
    } ctrl_t;

    ctrl_t            ctrl_d, ctrl_q;
    logic [NPINS-1:0] sync_vec, filt_vec, hit_vec;
    logic [NPINS-1:0] state_q, filt_en_q, wmask;
    logic             strap_ok;
    logic [NPINS-1:0] strap_val;

    pin_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_i(pin_i), .sync_o(sync_vec)
    );

    pin_filter #(.W(NPINS), .FILT(FILT_CYCLES)) u_filt (
        .clk(clk), .rst_n(rst_n), .raw_i(sync_vec),
        .en_i(ctrl_q.filt_en), .filt_o(filt_vec)
    );

    pin_event_detect #(.W(NPINS)) u_det (
        .clk(clk), .rst_n(rst_n), .level_i(filt_vec),
        .rise_en_i(ctrl_q.rise), .fall_en_i(ctrl_q.fall),
        .high_en_i(ctrl_q.high), .low_en_i(ctrl_q.low),
        .hit_o(hit_vec)
    );

    assign wmask     = reg_wdata_i[NPINS-1:0];
    assign state_q   = ctrl_q.state;
    assign filt_en_q = ctrl_q.filt_en;

    always_comb begin
        logic [NPINS-1:0] clr, set;
        ctrl_d = ctrl_q;
        clr    = '0;
        set    = '0;
        if (reg_we_i) begin
            unique case (reg_addr_i)
                REG_STATE:  clr            = wmask;
                REG_TEST:   set            = wmask;
                REG_ENABLE: ctrl_d.enable  = wmask;
                REG_RISE:   ctrl_d.rise    = wmask;
                REG_FALL:   ctrl_d.fall    = wmask;
                REG_HIGH:   ctrl_d.high    = wmask;
                REG_LOW:    ctrl_d.low     = wmask;
                REG_FILT:   ctrl_d.filt_en = wmask;
                default: ;
            endcase
        end
        // detection and test sets are applied after the clear, so set wins
        ctrl_d.state = (ctrl_q.state & ~clr) | hit_vec | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    if (STRAP_EN) begin : g_strap
        logic             ok_d, ok_q;
        logic [NPINS-1:0] val_d, val_q;

        always_comb begin
            ok_d  = ok_q;
            val_d = val_q;
            if (!ok_q && strap_en_i) begin
                ok_d  = 1'b1;
                val_d = sync_vec;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ok_q  <= 1'b0;
                val_q <= '0;
            end else begin
                ok_q  <= ok_d;
                val_q <= val_d;
            end
        end

        assign strap_ok  = ok_q;
        assign strap_val = val_q;
    end else begin : g_no_strap
        assign strap_ok  = 1'b0;
        assign strap_val = '0;
    end

    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_addr_i)
            REG_STATE:     reg_rdata_o[NPINS-1:0] = state_q;
            REG_ENABLE:    reg_rdata_o[NPINS-1:0] = ctrl_q.enable;
            REG_RISE:      reg_rdata_o[NPINS-1:0] = ctrl_q.rise;
            REG_FALL:      reg_rdata_o[NPINS-1:0] = ctrl_q.fall;
            REG_HIGH:      reg_rdata_o[NPINS-1:0] = ctrl_q.high;
            REG_LOW:       reg_rdata_o[NPINS-1:0] = ctrl_q.low;
            REG_FILT:      reg_rdata_o[NPINS-1:0] = filt_en_q;
            REG_LEVEL:     reg_rdata_o[NPINS-1:0] = filt_vec;
            REG_STRAP_OK:  reg_rdata_o[0]         = strap_ok;
            REG_STRAP_VAL: reg_rdata_o[NPINS-1:0] = strap_val;
            default: ;
        endcase
    end

    assign irq_o = state_q & ctrl_q.enable;
endmodule

// File: rtl/pin_event_checker.sv
module pin_event_checker
    import pin_event_pkg::*;
#(
    parameter int NPINS = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic [NPINS-1:0]  wmask,
    input logic [NPINS-1:0]  state_q,
    input logic [NPINS-1:0]  hit_vec,
    input logic [NPINS-1:0]  sync_vec,
    input logic [NPINS-1:0]  filt_vec,
    input logic [NPINS-1:0]  filt_en_q,
    input logic              strap_ok,
    input logic [NPINS-1:0]  strap_val
);
    AST_HIT_SETS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((state_q & $past(hit_vec)) == $past(hit_vec))); // R8

    AST_TEST_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we_i && reg_addr_i == REG_TEST) |=> ((state_q & $past(wmask)) == $past(wmask))); // R7

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we_i && reg_addr_i == REG_STATE)
        |=> ((state_q & $past(wmask) & ~$past(hit_vec)) == '0)); // R6

    AST_FILT_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((filt_vec ^ $past(filt_vec)) & $past(filt_en_q)
                   & (filt_vec ^ $past(sync_vec))) == '0)); // R3

    AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        strap_ok |=> (strap_ok && $stable(strap_val))); // R10
endmodule

bind pin_event_unit pin_event_checker #(.NPINS(NPINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .wmask(wmask), .state_q(state_q), .hit_vec(hit_vec), .sync_vec(sync_vec),
    .filt_vec(filt_vec), .filt_en_q(filt_en_q), .strap_ok(strap_ok),
    .strap_val(strap_val)
);

// File: tb/pin_event_unit_test.sv
module pin_event_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin = '0;
    logic        strap_en = 1'b0;
    logic        we = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, rdata_ns;
    logic [31:0] irq, irq_ns;
    int          checks = 0;
    int          failures = 0;
    bit          cmp_on = 1'b0;

    always #5 clk = ~clk;

    pin_event_unit uut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .strap_en_i(strap_en),
        .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq)
    );

    pin_event_unit #(.STRAP_EN(1'b0)) uut_ns (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .strap_en_i(strap_en),
        .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata_ns), .irq_o(irq_ns)
    );

    // behavioural reference, advanced on every rising edge
    logic [31:0] m_s1, m_s2, m_filt, m_prev, m_state, m_en;
    logic [31:0] m_rise, m_fall, m_high, m_low, m_fen, m_last;
    int          m_run [32];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_filt = '0; m_prev = '0; m_state = '0;
            m_en = '0; m_rise = '0; m_fall = '0; m_high = '0; m_low = '0;
            m_fen = '0; m_last = '0;
            for (int i = 0; i < 32; i++) m_run[i] = 0;
        end else begin
            logic [31:0] x, hit, clr, set, nfilt;
            x     = m_s2;
            nfilt = m_filt;
            for (int i = 0; i < 32; i++) begin
                if (x[i] == m_last[i]) m_run[i] = (m_run[i] >= 16) ? 16 : m_run[i] + 1;
                else                   m_run[i] = 1;
                if (!m_fen[i] || m_run[i] >= 16) nfilt[i] = x[i];
            end
            m_last = x;
            hit = (m_filt & ~m_prev & m_rise) | (~m_filt & m_prev & m_fall)
                | (m_filt & m_high) | (~m_filt & m_low);
            clr = (we && addr == 4'd0) ? wdata : '0;
            set = (we && addr == 4'd2) ? wdata : '0;
            m_state = (m_state & ~clr) | hit | set;
            if (we) begin
                case (addr)
                    4'd1: m_en   = wdata;
                    4'd3: m_rise = wdata;
                    4'd4: m_fall = wdata;
                    4'd5: m_high = wdata;
                    4'd6: m_low  = wdata;
                    4'd7: m_fen  = wdata;
                    default: ;
                endcase
            end
            m_prev = m_filt;
            m_filt = nfilt;
            m_s2   = m_s1;
            m_s1   = pin;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // R9: irq compared with the model on every falling edge
    always @(negedge clk) begin
        if (rst_n && cmp_on && !we) chk("R9 irq vs model", irq, m_state & m_en);
    end

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v;
        edges(4);
        rst_n = 1'b1;
        edges(1);
        cmp_on = 1'b1;

        // R1: reset values of every register
        for (int a = 0; a <= 10; a++) begin
            rd(4'(a), v);
            chk("R1 reset register", v, 32'h0);
        end
        chk("R1 irq after reset", irq, 32'h0);

        // R10: strap capture, then a later pulse is ignored
        pin = 32'hA5A5_3C3C;
        edges(3);
        strap_en = 1'b1;
        edges(1);
        strap_en = 1'b0;
        rd(4'd9, v);  chk("R10 strap valid", v, 32'h1);
        rd(4'd10, v); chk("R10 strap data", v, 32'hA5A5_3C3C);
        pin = 32'h1234_5678;
        edges(3);
        strap_en = 1'b1;
        edges(1);
        strap_en = 1'b0;
        edges(1);
        rd(4'd10, v); chk("R10 strap data kept", v, 32'hA5A5_3C3C);
        rd(4'd9, v);  chk("R10 strap valid kept", v, 32'h1);
        // R11: variant without strap capture
        addr = 4'd9;  #1; chk("R11 no-strap valid", rdata_ns, 32'h0);
        addr = 4'd10; #1; chk("R11 no-strap data", rdata_ns, 32'h0);
        pin = '0;
        edges(5);

        // R2: unfiltered latency of three edges
        pin[4] = 1'b1;
        edges(2);
        rd(4'd8, v); chk("R2 level before third edge", {31'b0, v[4]}, 32'h0);
        edges(1);
        rd(4'd8, v); chk("R2 level after third edge", {31'b0, v[4]}, 32'h1);

        // R4: rising and falling edge detection
        wr(4'd1, 32'hFFFF_FFFF);
        wr(4'd3, 32'h0000_0001);
        pin[1] = 1'b1;
        edges(5);
        wr(4'd4, 32'h0000_0002);
        pin[0] = 1'b1;
        edges(3);
        rd(4'd0, v); chk("R4 rise not yet", {31'b0, v[0]}, 32'h0);
        edges(1);
        rd(4'd0, v); chk("R4 rise seen", {31'b0, v[0]}, 32'h1);
        chk("R9 irq bit0", {31'b0, irq[0]}, 32'h1);
        pin[1] = 1'b0;
        edges(3);
        rd(4'd0, v); chk("R4 fall not yet", {31'b0, v[1]}, 32'h0);
        edges(1);
        rd(4'd0, v); chk("R4 fall seen", {31'b0, v[1]}, 32'h1);

        // R6: write 0 keeps, write 1 clears
        wr(4'd0, 32'h0);
        rd(4'd0, v); chk("R6 write zero keeps", v & 32'h3, 32'h3);
        wr(4'd0, 32'h1);
        rd(4'd0, v); chk("R6 write one clears", v & 32'h3, 32'h2);
        wr(4'd0, 32'h2);
        rd(4'd0, v); chk("R6 state vs model", v, m_state);

        // R5 and R8: level high reasserts through a clear
        wr(4'd5, 32'h0000_0004);
        edges(3);
        rd(4'd0, v); chk("R5 high mask, pin low", {31'b0, v[2]}, 32'h0);
        pin[2] = 1'b1;
        edges(5);
        rd(4'd0, v); chk("R5 level high sets", {31'b0, v[2]}, 32'h1);
        wr(4'd0, 32'h4);
        rd(4'd0, v); chk("R8 set wins over clear", {31'b0, v[2]}, 32'h1);
        wr(4'd5, 32'h0);
        edges(1);
        wr(4'd0, 32'h4);
        rd(4'd0, v); chk("R5 clears once level mask off", {31'b0, v[2]}, 32'h0);
        wr(4'd6, 32'h0000_0008);
        edges(2);
        rd(4'd0, v); chk("R5 level low sets", {31'b0, v[3]}, 32'h1);
        wr(4'd6, 32'h0);
        edges(1);
        wr(4'd0, 32'hFFFF_FFFF);

        // R7: test register sets, reads zero
        wr(4'd2, 32'h0010_0000);
        rd(4'd0, v); chk("R7 test sets bit 20", {31'b0, v[20]}, 32'h1);
        rd(4'd2, v); chk("R7 test reads zero", v, 32'h0);

        // R9: gating by enable
        wr(4'd1, 32'h0);
        chk("R9 irq gated off", irq, 32'h0);
        wr(4'd1, 32'hFFFF_FFFF);
        chk("R9 irq gated on", irq, m_state);
        wr(4'd0, 32'hFFFF_FFFF);

        // R3: filter rejects a short pulse, accepts a long one
        wr(4'd7, 32'h0000_0020);
        wr(4'd3, 32'h0000_0020);
        pin[5] = 1'b1;
        edges(10);
        pin[5] = 1'b0;
        edges(30);
        rd(4'd8, v); chk("R3 glitch rejected", {31'b0, v[5]}, 32'h0);
        rd(4'd0, v); chk("R3 no event from glitch", {31'b0, v[5]}, 32'h0);
        pin[5] = 1'b1;
        edges(17);
        rd(4'd8, v); chk("R3 level before 18th edge", {31'b0, v[5]}, 32'h0);
        edges(1);
        rd(4'd8, v); chk("R3 level after 18th edge", {31'b0, v[5]}, 32'h1);
        edges(1);
        rd(4'd0, v); chk("R3 filtered rise event", {31'b0, v[5]}, 32'h1);

        // random activity against the model
        wr(4'd7, 32'h0000_FFFF);
        wr(4'd3, 32'h1111_1111);
        wr(4'd4, 32'h2222_2222);
        wr(4'd5, 32'h0400_0040);
        wr(4'd6, 32'h0080_8000);
        wr(4'd1, 32'hFFFF_0FFF);
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            if (c % 97 == 0) begin
                we = 1'b1; addr = 4'd0; wdata = $urandom;
            end else begin
                we = 1'b0;
            end
            pin = pin ^ ($urandom & $urandom & $urandom & $urandom);
        end
        @(negedge clk);
        we = 1'b0;
        rd(4'd0, v); chk("R4 state vs model after random", v, m_state);
        rd(4'd8, v); chk("R3 level vs model after random", v, m_filt);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule